// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Front-End

This block sits between a simple register bus and the serial transfer engine of an SPI port. It holds a transmit queue, which the bus fills and the engine drains, and a receive queue, which the engine fills and the bus drains. It reports both fill levels, an eight-bit status word and eight latched interrupt sources. Serial shifting and clock generation are not part of it.

A bus write to the transmit-data address pushes one word. A bus read of the receive-data address pops one word. Each queue has a programmable watermark that drives its half flag. A push into a full queue is dropped. A pop from an empty receive queue returns zero. Both cases raise one sticky error flag.

Each status bit is also an interrupt source. Its latch sets on the rising edge of the condition. It is gated by an enable register and cleared by writing ones to a clear register. The interrupt line is high when any latched source is also enabled.

Top module: `spi_fifo_front`

## Requirements
- R1: The status word (address 2) holds, from bit 0 upward: engine busy, error, TX empty, TX half, TX full, RX empty, RX half, RX full. Empty means level 0 and full means level DEPTH. All upper bits read 0.
- R2: Each half flag is 1 exactly when its queue level is greater than or equal to its watermark register: TX at address 6, RX at address 7, low LW bits. The level never exceeds DEPTH.
- R3: A bus write to address 0 pushes into the TX queue. The engine takes words in write order on `eng_tx_word` with `eng_tx_take`. `eng_tx_ready` is high while the queue is not empty. The TX level reads at address 8.
- R4: `eng_rx_put` pushes into the RX queue. Bus reads of address 1 return the words in arrival order and pop them. The RX level reads at address 9.
- R5: A push into a full queue is dropped, from the bus into TX or from the engine into RX. The level stays at DEPTH and the error flag sets.
- R6: A bus read of address 1 while the RX queue is empty returns 0, leaves the level at 0 and sets the error flag.
- R7: The error flag stays set until a write to the clear register has bit 1 set. If an overflow or underflow happens in the same cycle as that clear, the flag stays set.
- R8: Interrupt status (address 4) bit k latches one cycle after status bit k rises, whether or not it is enabled.
- R9: A write to the clear register (address 5) clears each status bit written as 1. Bits written as 0 are unchanged. A new rising edge in the same cycle keeps the bit set.
- R10: `irq` is high exactly when some interrupt status bit is set and its enable bit (address 3) is set.
- R11: The data-write and clear addresses (0, 5) read as 0. Writes to read-only addresses (2, 4, 8, 9) change nothing.
- R12: After reset both queues are empty, both watermarks are DEPTH/2, enables and interrupt status are 0, and `irq` is low.
- R13: Status bit 0 follows `eng_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | One-cycle register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the addressed register (combinational) |
| eng_busy | input | 1 | Transfer engine busy |
| eng_tx_take | input | 1 | Engine takes the TX head word |
| eng_tx_word | output | DW | TX head word (0 when empty) |
| eng_tx_ready | output | 1 | TX queue not empty |
| eng_rx_put | input | 1 | Engine pushes a received word |
| eng_rx_word | input | DW | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The queues are run with four entries. Each watermark from 0 to DEPTH is tried against every fill level from empty to full. This separates a greater-or-equal compare from a strict one and from a fixed midpoint. Every fill goes one word past full and every drain one read past empty, which shows that overflow and underflow drop the word yet raise the error. The interrupt patterns put an edge on a masked source, toggle the enable, write a clear with zero bits, and make a clear coincide with a busy rise or an overflow. These tell an edge latch from a level mirror and show that a new event beats a clear.

// File: rtl/spi_ff_pkg.sv
package spi_ff_pkg;

  localparam int unsigned REG_AW = 4;
  localparam int unsigned NSRC   = 8;

  typedef enum logic [REG_AW-1:0] {
    A_TXDATA   = 4'd0,
    A_RXDATA   = 4'd1,
    A_STATUS   = 4'd2,
    A_IRQ_EN   = 4'd3,
    A_IRQ_STAT = 4'd4,
    A_IRQ_CLR  = 4'd5,
    A_TX_WM    = 4'd6,
    A_RX_WM    = 4'd7,
    A_TX_LVL   = 4'd8,
    A_RX_LVL   = 4'd9
  } reg_addr_e;

  // status / interrupt source bit positions
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_TXE  = 2;
  localparam int unsigned ST_TXH  = 3;
  localparam int unsigned ST_TXF  = 4;
  localparam int unsigned ST_RXE  = 5;
  localparam int unsigned ST_RXH  = 6;
  localparam int unsigned ST_RXF  = 7;

endpackage

// File: rtl/sff_queue.sv
module sff_queue #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          push_drop,
  output logic          pop_drop
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == LW'(DEPTH));
  assign do_push   = push & ~full;
  assign do_pop    = pop & ~empty;
  assign push_drop = push & full;
  assign pop_drop  = pop & empty;
  assign level     = cnt_q;
  assign head      = empty ? '0 : mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

endmodule

// File: rtl/sff_watermark.sv
module sff_watermark #(
  parameter int unsigned   LW     = 4,
  parameter logic [LW-1:0] RST_WM = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_val,
  input  logic [LW-1:0] level,
  output logic [LW-1:0] wm_q,
  output logic          half
);

  logic [LW-1:0] wm_n;

  always_comb begin
    wm_n = wm_q;
    if (wr_en) wm_n = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wm_q <= RST_WM;
    else        wm_q <= wm_n;
  end

  assign half = (level >= wm_q);

endmodule

// File: rtl/sff_irq_bank.sv
module sff_irq_bank #(
  parameter int unsigned  N        = 8,
  parameter logic [N-1:0] RST_COND = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         en_wr,
  input  logic [N-1:0] en_val,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_val,
  output logic [N-1:0] en_q,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] rise,
  output logic         irq
);

  logic [N-1:0] prev_q;
  logic [N-1:0] stat_n;
  logic [N-1:0] en_n;

  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      assign rise[g]   = cond[g] & ~prev_q[g];
      assign stat_n[g] = rise[g] | (stat_q[g] & ~(clr_wr & clr_val[g]));
    end
  endgenerate

  always_comb begin
    en_n = en_q;
    if (en_wr) en_n = en_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_COND;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= cond;
      stat_q <= stat_n;
      en_q   <= en_n;
    end
  end

  assign irq = |(stat_q & en_q);

endmodule

// File: rtl/spi_fifo_front.sv
module spi_fifo_front
  import spi_ff_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_tx_take,
  output logic [DW-1:0]     eng_tx_word,
  output logic              eng_tx_ready,
  input  logic              eng_rx_put,
  input  logic [DW-1:0]     eng_rx_word,
  output logic              irq
);

  localparam int unsigned   LW     = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] RST_WM = LW'(DEPTH / 2);
  localparam logic          HALF0  = ((DEPTH / 2) == 0);
  localparam logic [NSRC-1:0] RST_COND =
    {1'b0, HALF0, 1'b1, 1'b0, HALF0, 1'b1, 1'b0, 1'b0};

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // bus decode
  logic wr_hit, rd_hit;
  logic tx_push_req, rx_pop_req;
  logic en_wr, clr_wr, txwm_wr, rxwm_wr;

  assign wr_hit      = bus_sel & bus_write;
  assign rd_hit      = bus_sel & ~bus_write;
  assign tx_push_req = wr_hit & (bus_addr == A_TXDATA);
  assign rx_pop_req  = rd_hit & (bus_addr == A_RXDATA);
  assign en_wr       = wr_hit & (bus_addr == A_IRQ_EN);
  assign clr_wr      = wr_hit & (bus_addr == A_IRQ_CLR);
  assign txwm_wr     = wr_hit & (bus_addr == A_TX_WM);
  assign rxwm_wr     = wr_hit & (bus_addr == A_RX_WM);

  // queues
  logic [LW-1:0] tx_lvl, rx_lvl, tx_wm, rx_wm;
  logic          tx_empty, tx_full, tx_half, tx_drop, tx_under;
  logic          rx_empty, rx_full, rx_half, rx_drop, rx_under;
  logic [DW-1:0] rx_head;

  sff_queue #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_sync_n),
    .push(tx_push_req), .push_data(bus_wdata),
    .pop(eng_tx_take), .head(eng_tx_word),
    .level(tx_lvl), .empty(tx_empty), .full(tx_full),
    .push_drop(tx_drop), .pop_drop(tx_under)
  );

  sff_queue #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n),
    .push(eng_rx_put), .push_data(eng_rx_word),
    .pop(rx_pop_req), .head(rx_head),
    .level(rx_lvl), .empty(rx_empty), .full(rx_full),
    .push_drop(rx_drop), .pop_drop(rx_under)
  );

  sff_watermark #(.LW(LW), .RST_WM(RST_WM)) u_txwm (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(txwm_wr),
    .wr_val(bus_wdata[LW-1:0]), .level(tx_lvl), .wm_q(tx_wm), .half(tx_half)
  );

  sff_watermark #(.LW(LW), .RST_WM(RST_WM)) u_rxwm (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(rxwm_wr),
    .wr_val(bus_wdata[LW-1:0]), .level(rx_lvl), .wm_q(rx_wm), .half(rx_half)
  );

  assign eng_tx_ready = ~tx_empty;

  // sticky error: TX underflow from the engine side is ignored
  logic err_evt, err_q, err_n;
  assign err_evt = tx_drop | rx_drop | rx_under;

  always_comb begin
    err_n = err_q;
    if (clr_wr && bus_wdata[ST_ERR]) err_n = 1'b0;
    if (err_evt)                     err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (!rst_sync_n) err_q <= 1'b0;
    else                 err_q <= err_n;
  end

  // status word and interrupts
  logic [NSRC-1:0] status_w, irq_en_q, irq_stat_q, irq_rise;

  always_comb begin
    status_w          = '0;
    status_w[ST_BUSY] = eng_busy;
    status_w[ST_ERR]  = err_q;
    status_w[ST_TXE]  = tx_empty;
    status_w[ST_TXH]  = tx_half;
    status_w[ST_TXF]  = tx_full;
    status_w[ST_RXE]  = rx_empty;
    status_w[ST_RXH]  = rx_half;
    status_w[ST_RXF]  = rx_full;
  end

  sff_irq_bank #(.N(NSRC), .RST_COND(RST_COND)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .cond(status_w),
    .en_wr(en_wr), .en_val(bus_wdata[NSRC-1:0]),
    .clr_wr(clr_wr), .clr_val(bus_wdata[NSRC-1:0]),
    .en_q(irq_en_q), .stat_q(irq_stat_q), .rise(irq_rise), .irq(irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RXDATA:   bus_rdata = rx_head;
      A_STATUS:   bus_rdata = DW'(status_w);
      A_IRQ_EN:   bus_rdata = DW'(irq_en_q);
      A_IRQ_STAT: bus_rdata = DW'(irq_stat_q);
      A_TX_WM:    bus_rdata = DW'(tx_wm);
      A_RX_WM:    bus_rdata = DW'(rx_wm);
      A_TX_LVL:   bus_rdata = DW'(tx_lvl);
      A_RX_LVL:   bus_rdata = DW'(rx_lvl);
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_push_req,
  input logic          tx_full,
  input logic          eng_tx_take,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic          rx_pop_req,
  input logic          rx_empty,
  input logic [DW-1:0] bus_rdata,
  input logic          err_evt,
  input logic [7:0]    status_w,
  input logic          clr_wr,
  input logic [7:0]    clr_mask,
  input logic [7:0]    irq_rise,
  input logic [7:0]    irq_stat,
  input logic [7:0]    irq_en,
  input logic          irq
);

  // R5
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_req && tx_full && !eng_tx_take) |=> (tx_lvl == LW'(DEPTH)));

  // R6
  rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_req && rx_empty) |-> (bus_rdata == '0));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> status_w[1]);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (irq_rise == '0)) |=> ((irq_stat & $past(clr_mask)) == '0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  generate
    for (genvar g = 0; g < 8; g++) begin : g_lat
      // R8
      irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_w[g]) |=> irq_stat[g]);
    end
  endgenerate

endmodule

bind spi_fifo_front sff_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .tx_push_req(tx_push_req), .tx_full(tx_full), .eng_tx_take(eng_tx_take),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .rx_pop_req(rx_pop_req), .rx_empty(rx_empty), .bus_rdata(bus_rdata),
  .err_evt(err_evt), .status_w(status_w),
  .clr_wr(clr_wr), .clr_mask(bus_wdata[7:0]),
  .irq_rise(irq_rise), .irq_stat(irq_stat_q), .irq_en(irq_en_q), .irq(irq)
);

// File: tb/sim_spi_fifo_front.sv
module sim_spi_fifo_front;

  localparam int unsigned DW = 32;
  localparam int D = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_write;
  logic [3:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          eng_busy, eng_tx_take, eng_tx_ready, eng_rx_put, irq;
  logic [DW-1:0] eng_tx_word, eng_rx_word;

  int nvec = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  spi_fifo_front #(.DW(DW), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_tx_take(eng_tx_take), .eng_tx_word(eng_tx_word),
    .eng_tx_ready(eng_tx_ready), .eng_rx_put(eng_rx_put),
    .eng_rx_word(eng_rx_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_st(bit busy, bit err, int tl, int tw, int rl, int rw);
    logic [31:0] s;
    s    = '0;
    s[0] = busy;
    s[1] = err;
    s[2] = (tl == 0);
    s[3] = (tl >= tw);
    s[4] = (tl == D);
    s[5] = (rl == 0);
    s[6] = (rl >= rw);
    s[7] = (rl == D);
    return s;
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tx_take(output logic [31:0] d);
    @(negedge clk);
    eng_tx_take = 1'b1;
    #1 d = eng_tx_word;
    @(posedge clk); #1;
    eng_tx_take = 1'b0;
  endtask

  task automatic rx_put(input logic [31:0] d);
    @(negedge clk);
    eng_rx_put = 1'b1; eng_rx_word = d;
    @(posedge clk); #1;
    eng_rx_put = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_sel = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    eng_busy = 0; eng_tx_take = 0; eng_rx_put = 0; eng_rx_word = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R12 reset state, R1 layout
    bus_rd(4'd2, r); chk("R12 status", r, exp_st(0, 0, 0, D/2, 0, D/2));
    bus_rd(4'd6, r); chk("R12 tx wm", r, D/2);
    bus_rd(4'd7, r); chk("R12 rx wm", r, D/2);
    bus_rd(4'd4, r); chk("R12 irq stat", r, 0);
    bus_rd(4'd3, r); chk("R12 irq en", r, 0);
    bus_rd(4'd8, r); chk("R12 tx lvl", r, 0);
    bus_rd(4'd9, r); chk("R12 rx lvl", r, 0);
    chk("R12 irq", irq, 0);
    chk("R12 tx ready", eng_tx_ready, 0);

    // TX sweep: R1 R2 R3 R5 R7
    for (int w = 0; w <= D; w++) begin
      bus_wr(4'd6, w);
      for (int k = 0; k <= D; k++) begin
        bus_rd(4'd8, r); chk("R3 tx lvl", r, k);
        bus_rd(4'd2, r); chk("R2 tx status", r, exp_st(0, 0, k, w, 0, D/2));
        if (k < D) bus_wr(4'd0, 32'hA000 + w * 16 + k);
      end
      bus_wr(4'd0, 32'hDEAD);
      bus_rd(4'd8, r); chk("R5 tx overflow lvl", r, D);
      bus_rd(4'd2, r); chk("R5 tx overflow err", r, exp_st(0, 1, D, w, 0, D/2));
      bus_wr(4'd5, 32'hFF);
      bus_rd(4'd2, r); chk("R7 err cleared", r, exp_st(0, 0, D, w, 0, D/2));
      for (int k = 0; k < D; k++) begin
        tx_take(r); chk("R3 tx order", r, 32'hA000 + w * 16 + k);
      end
      chk("R3 tx ready low", eng_tx_ready, 0);
      tx_take(r); chk("R3 take on empty", r, 0);
      bus_rd(4'd2, r); chk("R3 take empty no err", r, exp_st(0, 0, 0, w, 0, D/2));
      idle(1);
      bus_wr(4'd5, 32'hFF);
    end

    // RX sweep: R2 R4 R5 R6
    for (int w = 0; w <= D; w++) begin
      bus_wr(4'd7, w);
      for (int k = 0; k <= D; k++) begin
        bus_rd(4'd9, r); chk("R4 rx lvl", r, k);
        bus_rd(4'd2, r); chk("R2 rx status", r, exp_st(0, 0, 0, D, k, w));
        if (k < D) rx_put(32'hB000 + w * 16 + k);
      end
      rx_put(32'hBEEF);
      bus_rd(4'd9, r); chk("R5 rx overflow lvl", r, D);
      bus_rd(4'd2, r); chk("R5 rx overflow err", r, exp_st(0, 1, 0, D, D, w));
      bus_wr(4'd5, 32'h02);
      for (int k = 0; k < D; k++) begin
        bus_rd(4'd1, r); chk("R4 rx order", r, 32'hB000 + w * 16 + k);
      end
      bus_rd(4'd1, r); chk("R6 underflow data", r, 0);
      bus_rd(4'd9, r); chk("R6 underflow lvl", r, 0);
      bus_rd(4'd2, r); chk("R6 underflow err", r, exp_st(0, 1, 0, D, 0, w));
      idle(1);
      bus_wr(4'd5, 32'hFF);
    end

    // interrupts: R8 R9 R10
    bus_wr(4'd6, 1);
    bus_wr(4'd7, D);
    bus_wr(4'd3, 0);
    idle(1);
    bus_wr(4'd5, 32'hFF);
    bus_rd(4'd4, r); chk("R9 all cleared", r, 0);
    bus_wr(4'd0, 32'h5);
    idle(1);
    bus_rd(4'd4, r); chk("R8 masked latch txh", r, 32'h08);
    chk("R10 masked irq low", irq, 0);
    bus_wr(4'd3, 32'h08);
    chk("R10 enabled irq high", irq, 1);
    bus_wr(4'd3, 32'h01);
    chk("R10 other enable irq low", irq, 0);
    bus_wr(4'd5, 32'h00);
    bus_rd(4'd4, r); chk("R9 zero clear keeps", r, 32'h08);
    bus_wr(4'd3, 32'h08);
    bus_wr(4'd5, 32'h08);
    bus_rd(4'd4, r); chk("R9 clear bit3", r, 0);
    chk("R10 irq after clear", irq, 0);
    tx_take(r);
    idle(1);
    bus_rd(4'd4, r); chk("R8 txe rise", r, 32'h04);
    bus_wr(4'd5, 32'hFF);

    // same-cycle busy rise and clear: R9 R13
    @(negedge clk);
    eng_busy = 1'b1;
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h01;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_write = 1'b0;
    bus_rd(4'd4, r); chk("R9 event beats clear", r, 32'h01);
    bus_rd(4'd2, r); chk("R13 busy bit", r, exp_st(1, 0, 0, 1, 0, D));
    bus_wr(4'd5, 32'h01);
    bus_rd(4'd4, r); chk("R9 held level no relatch", r, 0);
    eng_busy = 1'b0;
    bus_rd(4'd2, r); chk("R13 busy low", r, exp_st(0, 0, 0, 1, 0, D));

    // same-cycle overflow and error clear: R7
    for (int k = 0; k < D; k++) rx_put(k);
    idle(1);
    bus_wr(4'd5, 32'hFF);
    @(negedge clk);
    eng_rx_put = 1'b1; eng_rx_word = 32'h77;
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h02;
    @(posedge clk); #1;
    eng_rx_put = 1'b0; bus_sel = 1'b0; bus_write = 1'b0;
    bus_rd(4'd2, r); chk("R7 event beats clear", r, exp_st(0, 1, 0, 1, D, D));
    bus_rd(4'd4, r); chk("R8 err source latched", r & 32'h02, 32'h02);
    for (int k = 0; k < D; k++) begin
      bus_rd(4'd1, r); chk("R5 rx kept original", r, k);
    end
    idle(1);
    bus_wr(4'd5, 32'hFF);

    // read-only and write-only: R11
    bus_wr(4'd8, 32'h3);
    bus_rd(4'd8, r); chk("R11 tx lvl write ignored", r, 0);
    bus_wr(4'd9, 32'h3);
    bus_rd(4'd9, r); chk("R11 rx lvl write ignored", r, 0);
    bus_wr(4'd2, 32'hFF);
    bus_rd(4'd2, r); chk("R11 status write ignored", r, exp_st(0, 0, 0, 1, 0, D));
    bus_wr(4'd4, 32'hFF);
    bus_rd(4'd4, r); chk("R11 irq stat write ignored", r, 0);
    bus_rd(4'd0, r); chk("R11 txdata reads 0", r, 0);
    bus_rd(4'd5, r); chk("R11 clear reads 0", r, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule